// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Interlock

This block sits between a controller and the two gate drivers of a half-bridge. It takes two independent active-high requests, one for the upper switch and one for the lower switch, and produces two gate-enable outputs that are never both high. It decides which side conducts with a first-on-wins rule. It also uses two status bits from external comparators: one says the lower gate voltage has dropped below its off level, and one says the switch node has fallen below its low level.

The upper output turns on only after the lower gate is reported off and a short turn-on delay has run. The lower output turns on only when two things hold. The upper output must have been off for the same delay. A switch-node latch must also be set. The latch is set when the switch node is sensed low. It is also set by a timeout that runs while the lower request is present, so the lower side still turns on when the node never falls. Once set, the latch holds the lower-side decision until the lower request drops, so ringing on the node cannot toggle it.

An enable bit and two supply-good bits force both outputs off. Every input passes through a synchronizer. All delays are counted in clock cycles.

Top module: `bridge_interlock`

## Requirements
- R1: With both requests low, both outputs are low from the third clock edge after the inputs settle.
- R2: `gateHigh` and `gateLow` are never high in the same cycle.
- R3: `gateHigh` rises only if three conditions have held for TURN_ON consecutive evaluation cycles: `reqHigh` is high, `lowGateOff` is high and `gateLow` is low. Measured from a quiet state, it rises on edge TURN_ON+2 after the inputs change (6 edges with the defaults).
- R4: `gateLow` falls on the third edge after `reqLow` falls, with no further delay. Likewise, `gateHigh` falls on the third edge after `reqHigh` falls.
- R5: `gateLow` rises only when two things hold: `gateHigh` has been low for TURN_ON cycles, and the switch-node latch is set. After `gateHigh` falls, this is edge TURN_ON+4 after `reqHigh` falls (8 edges by default).
- R6: The switch-node latch is set by `nodeLow` or by TIMEOUT consecutive cycles of a present lower request, whichever comes first. It is cleared whenever the lower request is absent. On timeout alone, `gateLow` rises on edge TIMEOUT+3 after `reqLow` rises (27 edges by default).
- R7: While the latch is set and `reqLow` stays high, `nodeLow` toggling has no effect on `gateLow`.
- R8: While one output is high, a request for the other side has no effect until the first side's own request falls. If both sides become ready in the same cycle, the lower side wins.
- R9: `enable`, `supplyGoodLow` or `supplyGoodHigh` low forces both outputs low from the third edge after the change. It also clears the latch and the delay counters.
- R10: Reset (`rstN` low, asynchronous) makes both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable, low forces both outputs off |
| supplyGoodLow | input | 1 | Lower driver supply good |
| supplyGoodHigh | input | 1 | Upper driver supply good |
| reqHigh | input | 1 | Request for upper switch on |
| reqLow | input | 1 | Request for lower switch on |
| lowGateOff | input | 1 | Comparator: lower gate below its off level |
| nodeLow | input | 1 | Comparator: switch node below its low level |
| gateHigh | output | 1 | Upper gate enable |
| gateLow | output | 1 | Lower gate enable |

## Verification
The hardest situation to reach from the ports is the moment when both sides become ready in the same cycle. The first-on-wins rule normally keeps the two turn-on paths apart in time. Even the ordinary timeout path needs a lower request held for TIMEOUT cycles while the switch node never reports low. The stimulus therefore combines directed sequences with a long stretch of random request, comparator and enable patterns. The directed sequences place each edge at a known offset. The random stretch is biased toward long held levels so that counters run to completion. Every cycle of that stretch is compared against a behavioural model.

// File: rtl/bi_pkg.sv
package bi_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic hiCountEn;   // upper turn-on delay counts
    logic toCountEn;   // node timeout counts
    logic latchClr;    // lower request absent: clear latch
    logic highOn;      // current upper output state
  } ctlStrobes_t;

  // Status from datapath to control
  typedef struct packed {
    logic hiReady;     // upper delay reaches its last cycle
    logic offElapsed;  // upper output low long enough
    logic latchSet;    // switch-node latch state
  } dpStatus_t;
endpackage

// File: rtl/bi_sync.sv
module bi_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= dIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/bi_datapath.sv
module bi_datapath
  import bi_pkg::*;
#(
  parameter int TURN_ON = 4,
  parameter int TIMEOUT = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        nodeLowS,
  input  ctlStrobes_t strobes,
  output dpStatus_t   status
);
  localparam int HW = $clog2(TURN_ON + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [HW-1:0] HI_LAST = HW'(TURN_ON - 1);
  localparam logic [HW-1:0] OFF_MAX = HW'(TURN_ON);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT - 1);

  logic [HW-1:0] hiCnt, offCnt;
  logic [TW-1:0] toCnt;
  logic          nodeLatch, toHit;

  assign toHit = strobes.toCountEn && (toCnt == TO_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt     <= '0;
      offCnt    <= '0;
      toCnt     <= '0;
      nodeLatch <= 1'b0;
    end else begin
      if (!strobes.hiCountEn)      hiCnt <= '0;
      else if (hiCnt != HI_LAST)   hiCnt <= hiCnt + 1'b1;

      if (strobes.highOn)          offCnt <= '0;
      else if (offCnt != OFF_MAX)  offCnt <= offCnt + 1'b1;

      if (!strobes.toCountEn)      toCnt <= '0;
      else if (toCnt != TO_LAST)   toCnt <= toCnt + 1'b1;

      if (strobes.latchClr)               nodeLatch <= 1'b0;
      else if (nodeLowS || toHit)         nodeLatch <= 1'b1;
    end
  end

  assign status.hiReady    = (hiCnt == HI_LAST);
  assign status.offElapsed = (offCnt == OFF_MAX);
  assign status.latchSet   = nodeLatch;
endmodule

// File: rtl/bi_control.sv
module bi_control
  import bi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runS,
  input  logic        reqHighS,
  input  logic        reqLowS,
  input  logic        lowGateOffS,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        gateHigh,
  output logic        gateLow
);
  logic hiCond, hiFire, loFire, highNext, lowNext;

  always_comb begin
    hiCond   = runS && reqHighS && lowGateOffS && !gateHigh && !gateLow;
    loFire   = runS && reqLowS && !gateLow && !gateHigh
               && status.offElapsed && status.latchSet;
    // lower side wins a same-cycle tie
    hiFire   = hiCond && status.hiReady && !loFire;
    highNext = runS && reqHighS && (gateHigh || hiFire);
    lowNext  = runS && reqLowS && (gateLow || loFire);

    strobes.hiCountEn = hiCond;
    strobes.toCountEn = runS && reqLowS && !status.latchSet;
    strobes.latchClr  = !(runS && reqLowS);
    strobes.highOn    = gateHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateHigh <= 1'b0;
      gateLow  <= 1'b0;
    end else begin
      gateHigh <= highNext;
      gateLow  <= lowNext;
    end
  end
endmodule

// File: rtl/bridge_interlock.sv
module bridge_interlock
  import bi_pkg::*;
#(
  parameter int TURN_ON     = 4,
  parameter int TIMEOUT     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic supplyGoodLow,
  input  logic supplyGoodHigh,
  input  logic reqHigh,
  input  logic reqLow,
  input  logic lowGateOff,
  input  logic nodeLow,
  output logic gateHigh,
  output logic gateLow
);
  localparam int NIN = 7;

  logic [NIN-1:0] rawIn, syncIn;
  ctlStrobes_t    strobes;
  dpStatus_t      status;
  logic           runS;

  assign rawIn = {enable, supplyGoodLow, supplyGoodHigh,
                  reqHigh, reqLow, lowGateOff, nodeLow};

  bi_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(rawIn), .dOut(syncIn)
  );

  assign runS = syncIn[6] && syncIn[5] && syncIn[4];

  bi_control u_ctl (
    .clk(clk), .rstN(rstN), .runS(runS),
    .reqHighS(syncIn[3]), .reqLowS(syncIn[2]), .lowGateOffS(syncIn[1]),
    .status(status), .strobes(strobes),
    .gateHigh(gateHigh), .gateLow(gateLow)
  );

  bi_datapath #(.TURN_ON(TURN_ON), .TIMEOUT(TIMEOUT)) u_dp (
    .clk(clk), .rstN(rstN), .nodeLowS(syncIn[0]),
    .strobes(strobes), .status(status)
  );
endmodule

// File: rtl/bi_checker.sv
module bi_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic supplyGoodLow,
  input logic supplyGoodHigh,
  input logic reqHigh,
  input logic reqLow,
  input logic lowGateOff,
  input logic gateHigh,
  input logic gateLow
);
  localparam int LAT = SYNC_STAGES + 1;

  // R2
  excl_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHigh && gateLow));

  // R9
  run_off_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(enable && supplyGoodLow && supplyGoodHigh), LAT) |-> (!gateHigh && !gateLow));

  // R4
  low_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!reqLow, LAT) |-> !gateLow);

  // R4
  high_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!reqHigh, LAT) |-> !gateHigh);

  // R3
  high_needs_low_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHigh) |-> ($past(lowGateOff, LAT) && !$past(gateLow)));

  // R8
  low_waits_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLow) |-> !$past(gateHigh));
endmodule

bind bridge_interlock bi_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .supplyGoodLow(supplyGoodLow),
  .supplyGoodHigh(supplyGoodHigh), .reqHigh(reqHigh), .reqLow(reqLow),
  .lowGateOff(lowGateOff), .gateHigh(gateHigh), .gateLow(gateLow)
);

// File: tb/bridge_interlock_bench.sv
module bridge_interlock_bench;
  localparam int TON  = 4;
  localparam int TOUT = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1, supplyGoodLow = 1'b1, supplyGoodHigh = 1'b1;
  logic reqHigh = 1'b0, reqLow = 1'b0, lowGateOff = 1'b1, nodeLow = 1'b0;
  logic gateHigh, gateLow;

  int checks = 0;
  int fails = 0;
  string phase = "R10";
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bridge_interlock #(.TURN_ON(TON), .TIMEOUT(TOUT)) u_bridge_interlock (
    .clk(clk), .rstN(rstN), .enable(enable), .supplyGoodLow(supplyGoodLow),
    .supplyGoodHigh(supplyGoodHigh), .reqHigh(reqHigh), .reqLow(reqLow),
    .lowGateOff(lowGateOff), .nodeLow(nodeLow),
    .gateHigh(gateHigh), .gateLow(gateLow)
  );

  // Behavioural reference: two-deep input delay, then the rules
  bit [6:0] dq[$];
  bit mH, mL, mLatch;
  int cHi, cOff, cTo;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dq = {7'd0, 7'd0};
      mH = 0; mL = 0; mLatch = 0; cHi = 0; cOff = 0; cTo = 0;
    end else begin
      bit [6:0] v;
      bit run, rH, rL, lgo, nl, hiOk, loGo, hiGo, toOk, toEnd, nH, nL;
      v = dq[0];
      run = v[6] & v[5] & v[4];
      rH = v[3]; rL = v[2]; lgo = v[1]; nl = v[0];
      hiOk = run & rH & lgo & !mH & !mL;
      loGo = run & rL & !mL & !mH & (cOff >= TON) & mLatch;
      hiGo = hiOk & (cHi == TON - 1) & !loGo;
      toOk = run & rL & !mLatch;
      toEnd = toOk & (cTo == TOUT - 1);
      nH = run & rH & (mH | hiGo);
      nL = run & rL & (mL | loGo);
      cHi = hiOk ? ((cHi < TON - 1) ? cHi + 1 : cHi) : 0;
      cOff = mH ? 0 : ((cOff < TON) ? cOff + 1 : cOff);
      cTo = toOk ? ((cTo < TOUT - 1) ? cTo + 1 : cTo) : 0;
      mLatch = (run & rL) ? (mLatch | nl | toEnd) : 1'b0;
      mH = nH; mL = nL;
      void'(dq.pop_front());
      dq.push_back({enable, supplyGoodLow, supplyGoodHigh, reqHigh, reqLow, lowGateOff, nodeLow});
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison with the model
  always @(negedge clk) if (rstN && !finished) begin
    check(phase, gateHigh, mH, "gateHigh vs model");
    check(phase, gateLow, mL, "gateLow vs model");
    check("R2", gateHigh & gateLow, 1'b0, "both outputs high");
  end

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", gateHigh, 1'b0, "reset gateHigh");
    check("R10", gateLow, 1'b0, "reset gateLow");
    rstN = 1'b1;
    phase = "R1";
    edges(8);
    check("R1", gateHigh | gateLow, 1'b0, "idle outputs");

    // R3: upper turn-on timing
    phase = "R3";
    reqHigh = 1'b1;
    edges(TON + 1);
    check("R3", gateHigh, 1'b0, "before turn-on delay");
    edges(1);
    check("R3", gateHigh, 1'b1, "after turn-on delay");

    // R8: lower request ignored while upper on
    phase = "R8";
    reqLow = 1'b1; nodeLow = 1'b1;
    edges(30);
    check("R8", gateLow, 1'b0, "lower held off by upper");
    check("R8", gateHigh, 1'b1, "upper keeps priority");

    // R5: lower waits for upper off plus delay
    phase = "R5";
    reqHigh = 1'b0;
    edges(TON + 3);
    check("R5", gateLow, 1'b0, "lower before off delay");
    check("R4", gateHigh, 1'b0, "upper released");
    edges(1);
    check("R5", gateLow, 1'b1, "lower after off delay");

    // R7: node ringing after latch set
    phase = "R7";
    for (int i = 0; i < 12; i++) begin
      nodeLow = ~nodeLow;
      edges(1);
      check("R7", gateLow, 1'b1, "lower held through ringing");
    end
    nodeLow = 1'b0;

    // R8: upper request ignored while lower on
    phase = "R8";
    reqHigh = 1'b1;
    edges(30);
    check("R8", gateHigh, 1'b0, "upper held off by lower");

    // R4: immediate lower release
    phase = "R4";
    reqLow = 1'b0;
    edges(2);
    check("R4", gateLow, 1'b1, "lower before sync");
    edges(1);
    check("R4", gateLow, 1'b0, "lower released");
    reqHigh = 1'b0;
    edges(20);

    // R6: timeout path, node never low
    phase = "R6";
    reqLow = 1'b1;
    edges(TOUT + 2);
    check("R6", gateLow, 1'b0, "before timeout");
    edges(1);
    check("R6", gateLow, 1'b1, "timeout sets latch");
    reqLow = 1'b0;
    edges(10);
    reqLow = 1'b1;
    edges(TOUT + 2);
    check("R6", gateLow, 1'b0, "latch was cleared");
    reqLow = 1'b0;
    edges(10);

    // R3: lower gate not reported off blocks upper
    phase = "R3";
    lowGateOff = 1'b0; reqHigh = 1'b1;
    edges(20);
    check("R3", gateHigh, 1'b0, "blocked by lower gate status");
    lowGateOff = 1'b1;
    edges(TON + 1);
    check("R3", gateHigh, 1'b0, "delay restarted");
    edges(1);
    check("R3", gateHigh, 1'b1, "upper on");

    // R9: enable and supply-good force off
    phase = "R9";
    enable = 1'b0;
    edges(3);
    check("R9", gateHigh, 1'b0, "enable low");
    enable = 1'b1;
    edges(TON + 2);
    check("R9", gateHigh, 1'b1, "enable restored");
    supplyGoodHigh = 1'b0;
    edges(3);
    check("R9", gateHigh, 1'b0, "upper supply low");
    supplyGoodHigh = 1'b1; reqHigh = 1'b0; reqLow = 1'b1; nodeLow = 1'b1;
    edges(15);
    check("R9", gateLow, 1'b1, "lower on before supply drop");
    nodeLow = 1'b0; supplyGoodLow = 1'b0;
    edges(3);
    check("R9", gateLow, 1'b0, "lower supply low");
    supplyGoodLow = 1'b1;
    edges(TOUT + 2);
    check("R9", gateLow, 1'b0, "latch cleared by supply drop");
    reqLow = 1'b0;
    edges(6);
    check("R1", gateHigh | gateLow, 1'b0, "both requests low");

    // R2: long random stretch against the model
    phase = "R2";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 9) == 0) reqHigh = ~reqHigh;
      if ($urandom_range(0, 9) == 0) reqLow = ~reqLow;
      if ($urandom_range(0, 5) == 0) lowGateOff = ~lowGateOff;
      if ($urandom_range(0, 4) == 0) nodeLow = ($urandom_range(0, 3) == 0);
      enable = ($urandom_range(0, 60) != 0);
      supplyGoodLow = ($urandom_range(0, 80) != 0);
      supplyGoodHigh = ($urandom_range(0, 80) != 0);
      edges(1);
    end
    finish_run();
  end
endmodule